// File: doc/BRIEF.md
# Memory protection region matcher

This block takes the address of each bus access and compares it against eight programmable protection regions. Every region has:

- a base address;
- a power-of-two size code;
- an enable bit;
- a bufferable attribute;
- an eight-bit mask that removes individual eighths of the region from matching.

A single-cycle write port loads all fields of one region at a time. The lookup is registered. One clock after an address is presented, the block reports three things: whether any live region covers that address, the index of the winning region, and that region's bufferable bit.

The block is meant to sit beside an access path as the matching stage of a protection unit. Permission decoding and fault reporting are built on its hit and index outputs elsewhere.

Top module: `mpu_region_match`

## Requirements
- R1: A region with size code s (4 to 31) covers 2^(s+1) bytes. The configured base is first aligned down to that size, and an address hits when it lies in [aligned base, aligned base + 2^(s+1)).
- R2: A region whose size code is 0, 1, 2 or 3 never hits.
- R3: A region whose enable bit is 0 never hits.
- R4: For a region with size code 7 or more (256 bytes and up), the sub-region index k is address bits [s:s-2]. When bit k of the region's mask is 1, addresses in sub-region k do not hit that region.
- R5: For a region with size code 6 or less (128 bytes and down), the mask has no effect and the whole region hits.
- R6: When several regions hit the same address, the region with the highest index wins. Its index appears on idx_o and hit_o is 1.
- R7: buf_o carries the bufferable bit of the winning region (1 = bufferable).
- R8: When no region hits, hit_o, idx_o and buf_o are all 0.
- R9: The result for an address presented in one cycle appears on the outputs after the next rising clock edge, and it holds while the address and the configuration stay unchanged.
- R10: A region write accepted at a clock edge does not affect the lookup sampled at that same edge. It does affect every lookup sampled at later edges.
- R11: Reset clears every enable bit, so no address hits after reset until a region is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one region |
| cfg_idx | input | IDX_W (3) | Region to write |
| cfg_base | input | ADDR_W (32) | Region base address |
| cfg_size | input | 5 | Size code: the region spans 2^(code+1) bytes |
| cfg_srd | input | 8 | Sub-region mask, 1 removes that eighth |
| cfg_en | input | 1 | Region enable |
| cfg_buf | input | 1 | Bufferable attribute |
| acc_addr | input | ADDR_W (32) | Access address to look up |
| hit_o | output | 1 | Some live region covers the address |
| idx_o | output | IDX_W (3) | Winning region index |
| buf_o | output | 1 | Bufferable attribute of the winning region |

## Verification
Every lookup result is due exactly one rising edge after its address is driven. The bench drives the address on a falling edge, lets one rising edge pass, and compares all three outputs on the following falling edge. A configuration write is driven on a falling edge and is taken in at the next rising edge. The model is updated only after that edge, so the expected values always describe the configuration that the sampled lookup saw. One test drives a write and a covered address together: it expects a miss one edge later and a hit one edge after that.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int SIZE_W = 5;
    localparam int SUB_N  = 8;

    // smallest legal size code (32 bytes)
    localparam logic [SIZE_W-1:0] MIN_CODE     = 5'd4;
    // smallest size code where the sub-region mask applies (256 bytes)
    localparam logic [SIZE_W-1:0] SUB_MIN_CODE = 5'd7;
    // sub-region index sits two bits below the top covered bit
    localparam logic [SIZE_W-1:0] SUB_OFS      = 5'd2;

    typedef struct packed {
        logic              en;
        logic              bufb;
        logic [SIZE_W-1:0] size;
        logic [SUB_N-1:0]  srd;
    } rgn_attr_t;

endpackage

// File: rtl/mpu_region_file.sv
module mpu_region_file
    import mpu_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [ADDR_W-1:0]                 wr_base,
    input  rgn_attr_t                         wr_attr,
    output logic [NUM_RGN-1:0][ADDR_W-1:0]    base_o,
    output rgn_attr_t [NUM_RGN-1:0]           attr_o
);

    typedef struct packed {
        logic [NUM_RGN-1:0][ADDR_W-1:0] base;
        rgn_attr_t [NUM_RGN-1:0]        attr;
    } file_t;

    file_t file_d, file_q;

    always_comb begin
        file_d = file_q;
        if (wr_en && (int'(wr_idx) < NUM_RGN)) begin
            file_d.base[wr_idx] = wr_base;
            file_d.attr[wr_idx] = wr_attr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            file_q <= '0;
        end else begin
            file_q <= file_d;
        end
    end

    assign base_o = file_q.base;
    assign attr_o = file_q.attr;

endmodule

// File: rtl/mpu_region_cmp.sv
module mpu_region_cmp
    import mpu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  rgn_attr_t         attr,
    output logic              hit
);

    logic              legal;
    logic              mismatch;
    logic              masked;
    logic [SIZE_W-1:0] sub_lsb;
    logic [2:0]        sub_idx;

    always_comb begin
        legal    = (attr.size >= MIN_CODE);
        mismatch = 1'b0;
        // only bits above the size code take part in the compare,
        // which aligns the base down to the region size
        for (int b = 0; b < ADDR_W; b++) begin
            if (b > int'(attr.size)) begin
                mismatch = mismatch | (addr[b] ^ base[b]);
            end
        end
        sub_lsb = attr.size - SUB_OFS;
        sub_idx = 3'(addr >> sub_lsb);
        masked  = (attr.size >= SUB_MIN_CODE) && attr.srd[sub_idx];
        hit     = attr.en && legal && !mismatch && !masked;
    end

endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel #(
    parameter int NUM_RGN = 8,
    parameter int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
    input  logic [NUM_RGN-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   sel
);

    always_comb begin
        any = 1'b0;
        sel = '0;
        // ascending scan: the last hit seen, the highest index, wins
        for (int i = 0; i < NUM_RGN; i++) begin
            if (hits[i]) begin
                any = 1'b1;
                sel = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [SIZE_W-1:0]     cfg_size,
    input  logic [SUB_N-1:0]      cfg_srd,
    input  logic                  cfg_en,
    input  logic                  cfg_buf,
    input  logic [ADDR_W-1:0]     acc_addr,
    output logic                  hit_o,
    output logic [IDX_W-1:0]      idx_o,
    output logic                  buf_o
);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             bufb;
    } res_t;

    rgn_attr_t                      wr_attr;
    logic [NUM_RGN-1:0][ADDR_W-1:0] rgn_base;
    rgn_attr_t [NUM_RGN-1:0]        rgn_attr;
    logic [NUM_RGN-1:0]             rgn_hit;
    logic                           any_hit;
    logic [IDX_W-1:0]               win_idx;
    res_t                           res_d, res_q;

    always_comb begin
        wr_attr.en   = cfg_en;
        wr_attr.bufb = cfg_buf;
        wr_attr.size = cfg_size;
        wr_attr.srd  = cfg_srd;
    end

    mpu_region_file #(
        .NUM_RGN (NUM_RGN),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_base (cfg_base),
        .wr_attr (wr_attr),
        .base_o  (rgn_base),
        .attr_o  (rgn_attr)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        mpu_region_cmp #(
            .ADDR_W (ADDR_W)
        ) u_cmp (
            .addr (acc_addr),
            .base (rgn_base[g]),
            .attr (rgn_attr[g]),
            .hit  (rgn_hit[g])
        );
    end

    mpu_prio_sel #(
        .NUM_RGN (NUM_RGN),
        .IDX_W   (IDX_W)
    ) u_sel (
        .hits (rgn_hit),
        .any  (any_hit),
        .sel  (win_idx)
    );

    always_comb begin
        res_d.hit  = any_hit;
        res_d.idx  = any_hit ? win_idx : '0;
        res_d.bufb = any_hit ? rgn_attr[win_idx].bufb : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit_o = res_q.hit;
    assign idx_o = res_q.idx;
    assign buf_o = res_q.bufb;

endmodule

// File: rtl/mpu_region_match_chk.sv
module mpu_region_match_chk
    import mpu_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [SIZE_W-1:0] cfg_size,
    input logic              cfg_en,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              hit_o,
    input logic [IDX_W-1:0]  idx_o,
    input logic              buf_o
);

    // shadow of which regions can hit at all (enabled, legal size)
    logic [NUM_RGN-1:0] live_q;
    logic [NUM_RGN-1:0] live_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q    <= '0;
            live_prev <= '0;
        end else begin
            live_prev <= live_q;
            if (cfg_we && (int'(cfg_idx) < NUM_RGN)) begin
                live_q[cfg_idx] <= cfg_en && (cfg_size >= MIN_CODE);
            end
        end
    end

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (idx_o == '0) && !buf_o); // R8

    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> live_prev[idx_o]); // R3

    AST_NONE_LIVE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == '0) |=> !hit_o); // R11

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(acc_addr) && !$past(cfg_we)) |=> $stable({hit_o, idx_o, buf_o})); // R9

endmodule

bind mpu_region_match mpu_region_match_chk #(
    .NUM_RGN (NUM_RGN),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_size (cfg_size),
    .cfg_en   (cfg_en),
    .acc_addr (acc_addr),
    .hit_o    (hit_o),
    .idx_o    (idx_o),
    .buf_o    (buf_o)
);

// File: tb/mpu_region_match_bench.sv
`timescale 1ns/1ps
module mpu_region_match_bench;

    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic [7:0]  cfg_srd = '0;
    logic        cfg_en = 1'b0;
    logic        cfg_buf = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        hit_o;
    logic [2:0]  idx_o;
    logic        buf_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model of the region table
    logic [31:0] m_base [NR];
    logic [4:0]  m_size [NR];
    logic [7:0]  m_srd  [NR];
    logic        m_en   [NR];
    logic        m_buf  [NR];

    always #4 clk = ~clk;

    mpu_region_match u_mpu_region_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .cfg_size (cfg_size),
        .cfg_srd  (cfg_srd),
        .cfg_en   (cfg_en),
        .cfg_buf  (cfg_buf),
        .acc_addr (acc_addr),
        .hit_o    (hit_o),
        .idx_o    (idx_o),
        .buf_o    (buf_o)
    );

    task automatic check3(input string tag, input logic eh, input logic [2:0] ei, input logic eb);
        tests++;
        if (hit_o !== eh || idx_o !== ei || buf_o !== eb) begin
            fails++;
            $display("FAIL %s: got hit=%0b idx=%0d buf=%0b expected hit=%0b idx=%0d buf=%0b",
                     tag, hit_o, idx_o, buf_o, eh, ei, eb);
        end
    endtask

    // arithmetic expectation: span, aligned base, byte offset into eighths
    task automatic expect_of(input logic [31:0] a, output logic eh, output logic [2:0] ei,
                             output logic eb);
        eh = 1'b0; ei = '0; eb = 1'b0;
        for (int i = 0; i < NR; i++) begin
            longint unsigned span, ab, a64, k;
            if (!m_en[i] || m_size[i] < 5'd4) continue;
            span = 64'd1 << (int'(m_size[i]) + 1);
            ab   = longint'(m_base[i]) & ~(span - 1);
            a64  = longint'(a);
            if (a64 < ab || a64 >= ab + span) continue;
            k = (a64 - ab) / (span / 8);
            if (m_size[i] >= 5'd7 && m_srd[i][k[2:0]]) continue;
            eh = 1'b1; ei = 3'(i); eb = m_buf[i];
        end
    endtask

    task automatic write_rgn(input int i, input logic [31:0] b, input logic [4:0] s,
                             input logic [7:0] m, input logic e, input logic bf);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_base = b; cfg_size = s;
        cfg_srd = m; cfg_en = e; cfg_buf = bf;
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[i] = b; m_size[i] = s; m_srd[i] = m; m_en[i] = e; m_buf[i] = bf;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NR; i++) write_rgn(i, 32'h0, 5'd0, 8'h0, 1'b0, 1'b0);
    endtask

    task automatic lookup(input logic [31:0] a, input string tag);
        logic eh, eb;
        logic [2:0] ei;
        expect_of(a, eh, ei, eb);
        @(negedge clk);
        acc_addr = a;
        @(posedge clk);
        @(negedge clk);
        check3(tag, eh, ei, eb);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_srd[i] = '0; m_en[i] = 1'b0; m_buf[i] = 1'b0;
        end
        acc_addr = 32'h0000_0010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R11 reset state", 1'b0, 3'd0, 1'b0);
        lookup(32'h0000_0000, "R11 after reset");
        lookup(32'h2000_0000, "R8 miss after reset");

        // R1 and R2: size codes with unaligned base, probes at the edges
        for (int s = 0; s < 16; s++) begin
            longint unsigned span, ab;
            string tg;
            tg = (s < 4) ? "R2 reserved size" : "R1 span edges";
            write_rgn(0, 32'h2000_0123, 5'(s), 8'h00, 1'b1, 1'b1);
            span = 64'd1 << (s + 1);
            ab   = 64'h2000_0000;
            lookup(32'(ab - 1), tg);
            lookup(32'(ab), tg);
            lookup(32'(ab + span / 2), tg);
            lookup(32'(ab + span - 1), tg);
            lookup(32'(ab + span), tg);
        end
        // R3: disabled region
        write_rgn(0, 32'h2000_0000, 5'd10, 8'h00, 1'b0, 1'b1);
        lookup(32'h2000_0000, "R3 disabled");
        lookup(32'h2000_0400, "R3 disabled");

        // R4: single masked eighth, then a mixed mask, 1 KB region
        for (int k = 0; k < 9; k++) begin
            logic [7:0] m;
            m = (k < 8) ? 8'(1 << k) : 8'hA5;
            write_rgn(0, 32'h2000_0000, 5'd9, m, 1'b1, 1'b0);
            for (int o = -64; o < 1024 + 64; o += 32)
                lookup(32'(64'h2000_0000 + o), "R4 sub-region mask");
        end
        // R4 on a large region: index from high address bits
        write_rgn(0, 32'h4000_0000, 5'd27, 8'h5A, 1'b1, 1'b1);
        for (int k = 0; k < 8; k++)
            lookup(32'h4000_0000 + 32'(k) * 32'h0200_0000 + 32'h1234, "R4 large region");

        // R5: small regions ignore the mask
        for (int s = 4; s < 7; s++) begin
            write_rgn(0, 32'h2000_0000, 5'(s), 8'hFF, 1'b1, 1'b1);
            for (int o = -16; o < 144; o += 8)
                lookup(32'(64'h2000_0000 + o), "R5 mask ignored");
        end

        // R6 and R7: nested overlapping regions, alternate bufferable
        clear_all();
        for (int i = 0; i < NR; i++)
            write_rgn(i, 32'h3000_0000, 5'(8 + i), (i == 4) ? 8'h0C : 8'h00, 1'b1, 1'(i % 2));
        for (int o = 0; o < 32'h1_0040; o += 64)
            lookup(32'h3000_0000 + 32'(o), "R6 R7 priority");
        // a higher region disabled or reserved hands the win downward
        write_rgn(7, 32'h3000_0000, 5'd15, 8'h00, 1'b0, 1'b1);
        write_rgn(6, 32'h3000_0000, 5'd2, 8'h00, 1'b1, 1'b1);
        for (int o = 0; o < 32'h1_0040; o += 256)
            lookup(32'h3000_0000 + 32'(o), "R6 R3 lower winner");

        // R10: write and covered address in the same cycle
        clear_all();
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_base = 32'h5000_0000; cfg_size = 5'd11;
        cfg_srd = 8'h00; cfg_en = 1'b1; cfg_buf = 1'b1;
        acc_addr = 32'h5000_0100;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        check3("R10 same-edge write unseen", 1'b0, 3'd0, 1'b0);
        m_base[1] = 32'h5000_0000; m_size[1] = 5'd11; m_srd[1] = 8'h00;
        m_en[1] = 1'b1; m_buf[1] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check3("R10 write seen next", 1'b1, 3'd1, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check3("R9 result holds", 1'b1, 3'd1, 1'b1);

        // R11: reset in mid-run clears enables
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) m_en[i] = 1'b0;
        lookup(32'h5000_0100, "R11 reset clears");
        check3("R11 reset clears", 1'b0, 3'd0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule